// File: doc/BRIEF.md
# Receive FIFO Burst Read Port

This block is the read side of a host-facing parallel bus slave, modelled on a system clock. The host frames each read with two active-low strobes, a chip select and a read strobe. A read cycle exists only while both are low. A sideband FIFO-select input, sampled when a cycle opens, chooses what the cycle reads. When FIFO-select is high, the upper address bits play no part and the cycle reads the receive data FIFO. This lets a host that must advance its address on every access drain the FIFO with an unbroken burst. When FIFO-select is low, the cycle reads a small identification register file indexed by the whole address.

The strobes pass through a synchronizer. The cycle opens on the synchronized falling edge of "both low" and closes on its rising edge. The FIFO is popped once, when a completed cycle closes, however long the strobes were held. The bus runs either 32 bits wide or 16 bits wide. In 16-bit mode each FIFO entry is read as two halves, and address bit 1 selects the half. The pop waits for the read of the high half. The FIFO is filled from the receive side through a simple push port.

Top module: `rxq_burst_port`

## Requirements
- R1: The data drivers (`host_doe`) are enabled only while a read cycle is open. A cycle needs both `host_cs_n` and `host_rd_n` low, so one strobe low on its own never enables the drivers. The drivers are released within a few clocks after either strobe rises.
- R2: With `host_fifo_sel` high at cycle start, the cycle returns the FIFO head entry whatever `host_addr[6:1]` holds. Successive cycles return successive entries in push order.
- R3: A FIFO-path cycle that completes pops exactly one entry, whether its strobes were held for 5 or for 40 clocks.
- R4: In 32-bit mode (`host_bus16` = 0), `host_doe` = 2'b11 and `host_dout` carries the full 32-bit entry.
- R5: In 16-bit mode (`host_bus16` = 1), `host_doe` = 2'b01 and bits [31:16] are never enabled. `host_addr[0]` (bus address bit 1) = 0 returns entry bits [15:0]. `host_addr[0]` = 1 returns bits [31:16]. Only a high-half cycle pops the entry.
- R6: A FIFO-path cycle on an empty FIFO returns zero and does not pop. It sets `rxq_underflow`, which stays set until reset.
- R7: With `host_fifo_sel` low, the cycle returns the register word {REG_TAG[15:0], 9'b0, host_addr[6:0]}. In 16-bit mode only its low half is returned, with the upper lines undriven. A register cycle never pops the FIFO.
- R8: `rxq_full` is high when FIFO_DEPTH entries are stored. A push while full is dropped.
- R9: The strobes may fall and rise in either order. The cycle opens once both are low and closes when the first one rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| host_cs_n | input | 1 | Host chip select, active low |
| host_rd_n | input | 1 | Host read strobe, active low |
| host_addr | input | ADDR_W | Host word address, bus bits [7:1] |
| host_fifo_sel | input | 1 | High steers the cycle to the receive FIFO |
| host_bus16 | input | 1 | 1 = 16-bit bus, 0 = 32-bit bus |
| host_dout | output | DATA_W | Read data toward the pads |
| host_doe | output | 2 | Pad enables: bit 0 low half, bit 1 high half |
| rxq_push | input | 1 | Receive-side write strobe |
| rxq_push_data | input | DATA_W | Receive-side write data |
| rxq_full | output | 1 | FIFO holds FIFO_DEPTH entries |
| rxq_underflow | output | 1 | Sticky: a FIFO read found the FIFO empty |

## Verification
The bench builds the port with DATA_W = 32, ADDR_W = 7, SYNC_STAGES = 2 and FIFO_DEPTH = 4. The shallow FIFO lets a few pushes reach the full boundary and the dropped-push case. It also lets the bench drain the FIFO to empty so that an underflowing read can be seen. The 7-bit address puts the tag, the zero pad and the address into distinct fields of the register word. This makes a register-path read easy to tell from a FIFO read in both bus widths. Strobe order, long holds and single-strobe activity are driven against a queue model of the FIFO contents.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

  // Source that an open read cycle is returning.
  typedef enum logic [1:0] {
    SRC_NONE  = 2'd0,
    SRC_REG   = 2'd1,
    SRC_FIFO  = 2'd2,
    SRC_EMPTY = 2'd3
  } rd_src_e;

endpackage

// File: rtl/rxq_strobe_sync.sv
// Brings both host strobes into the clock domain and frames read cycles.
module rxq_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic rd_n,
  output logic act,
  output logic start,
  output logic stop
);

  localparam int MSB = SYNC_STAGES - 1;

  logic [MSB:0] cs_pipe_q, cs_pipe_d;
  logic [MSB:0] rd_pipe_q, rd_pipe_d;
  logic         act_q, act_d;

  generate
    if (SYNC_STAGES > 1) begin : g_multi
      always_comb begin
        cs_pipe_d = {cs_pipe_q[MSB-1:0], cs_n};
        rd_pipe_d = {rd_pipe_q[MSB-1:0], rd_n};
      end
    end else begin : g_single
      always_comb begin
        cs_pipe_d = cs_n;
        rd_pipe_d = rd_n;
      end
    end
  endgenerate

  always_comb begin
    act   = ~cs_pipe_q[MSB] & ~rd_pipe_q[MSB];
    act_d = act;
    start = act & ~act_q;
    stop  = ~act & act_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cs_pipe_q <= '1;
      rd_pipe_q <= '1;
      act_q     <= 1'b0;
    end else begin
      cs_pipe_q <= cs_pipe_d;
      rd_pipe_q <= rd_pipe_d;
      act_q     <= act_d;
    end
  end

endmodule

// File: rtl/rxq_fifo.sv
// Receive data FIFO: push from the receive side, pop from the host port.
module rxq_fifo #(
  parameter int DATA_W = 32,
  parameter int DEPTH  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              push,
  input  logic [DATA_W-1:0] push_data,
  input  logic              pop,
  output logic [DATA_W-1:0] head,
  output logic              empty,
  output logic              full
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CNT_W = $clog2(DEPTH + 1);
  localparam logic [PTR_W-1:0] LAST = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [DATA_W-1:0] mem [DEPTH];
  logic [PTR_W-1:0]  wr_ptr_q, wr_ptr_d;
  logic [PTR_W-1:0]  rd_ptr_q, rd_ptr_d;
  logic [CNT_W-1:0]  cnt_q, cnt_d;
  logic              push_ok, pop_ok;

  always_comb begin
    empty   = (cnt_q == '0);
    full    = (cnt_q == FULL_CNT);
    push_ok = push & ~full;
    pop_ok  = pop & ~empty;
    head    = mem[rd_ptr_q];

    wr_ptr_d = wr_ptr_q;
    rd_ptr_d = rd_ptr_q;
    cnt_d    = cnt_q;
    if (push_ok) wr_ptr_d = (wr_ptr_q == LAST) ? '0 : wr_ptr_q + 1'b1;
    if (pop_ok)  rd_ptr_d = (rd_ptr_q == LAST) ? '0 : rd_ptr_q + 1'b1;
    case ({push_ok, pop_ok})
      2'b10:   cnt_d = cnt_q + 1'b1;
      2'b01:   cnt_d = cnt_q - 1'b1;
      default: cnt_d = cnt_q;
    endcase
  end

  // Storage: one clock-enabled register row per entry.
  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
      always_ff @(posedge clk) begin
        if (push_ok && (wr_ptr_q == PTR_W'(i))) begin
          mem[i] <= push_data;
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_d;
      if (pop_ok)  rd_ptr_q <= rd_ptr_d;
      if (push_ok ^ pop_ok) cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/rxq_read_ctrl.sv
// Per-cycle source selection, data capture, pad enables and pop control.
module rxq_read_ctrl
  import rxq_pkg::*;
#(
  parameter int          DATA_W  = 32,
  parameter int          ADDR_W  = 7,
  parameter logic [15:0] REG_TAG = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              act,
  input  logic              start,
  input  logic              stop,
  input  logic              fifo_sel,
  input  logic [ADDR_W-1:0] addr,
  input  logic              bus16,
  input  logic [DATA_W-1:0] head,
  input  logic              empty,
  output logic              pop,
  output logic [DATA_W-1:0] dout,
  output logic [1:0]        doe,
  output logic              underflow
);

  localparam int HALF_W = DATA_W / 2;
  localparam int PAD_W  = DATA_W - 16 - ADDR_W;

  function automatic logic [DATA_W-1:0] reg_word(input logic [ADDR_W-1:0] a);
    return {REG_TAG, {PAD_W{1'b0}}, a};
  endfunction

  logic              cyc_q, cyc_d;
  logic              b16_q, b16_d;
  logic              arm_q, arm_d;
  rd_src_e           src_q, src_d;
  logic [DATA_W-1:0] word_q, word_d;
  logic              uflow_q, uflow_d;
  logic              cyc_en;
  logic [DATA_W-1:0] fifo_word, reg_w;

  always_comb begin
    // Half select: bus address bit 1 is host_addr[0].
    if (bus16) begin
      fifo_word = addr[0] ? {{HALF_W{1'b0}}, head[DATA_W-1:HALF_W]}
                          : {{HALF_W{1'b0}}, head[HALF_W-1:0]};
    end else begin
      fifo_word = head;
    end
    reg_w = reg_word(addr);
    if (bus16) reg_w[DATA_W-1:HALF_W] = '0;
  end

  always_comb begin
    cyc_d   = cyc_q;
    b16_d   = b16_q;
    arm_d   = arm_q;
    src_d   = src_q;
    word_d  = word_q;
    uflow_d = uflow_q;
    cyc_en  = start | stop;
    if (start) begin
      cyc_d = 1'b1;
      b16_d = bus16;
      arm_d = 1'b0;
      if (!fifo_sel) begin
        src_d  = SRC_REG;
        word_d = reg_w;
      end else if (empty) begin
        src_d   = SRC_EMPTY;
        word_d  = '0;
        uflow_d = 1'b1;
      end else begin
        src_d  = SRC_FIFO;
        word_d = fifo_word;
        arm_d  = ~bus16 | addr[0];
      end
    end else if (stop) begin
      cyc_d = 1'b0;
      arm_d = 1'b0;
      src_d = SRC_NONE;
    end
  end

  always_comb begin
    pop       = stop & cyc_q & arm_q & (src_q == SRC_FIFO);
    doe[0]    = cyc_q & act;
    doe[1]    = cyc_q & act & ~b16_q;
    dout      = word_q;
    underflow = uflow_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cyc_q   <= 1'b0;
      b16_q   <= 1'b0;
      arm_q   <= 1'b0;
      src_q   <= SRC_NONE;
      word_q  <= '0;
      uflow_q <= 1'b0;
    end else begin
      if (cyc_en) begin
        cyc_q <= cyc_d;
        b16_q <= b16_d;
        arm_q <= arm_d;
        src_q <= src_d;
      end
      if (start) word_q <= word_d;
      if (start) uflow_q <= uflow_d;
    end
  end

endmodule

// File: rtl/rxq_burst_port.sv
// Host-facing receive FIFO burst read port.
module rxq_burst_port #(
  parameter int          DATA_W      = 32,
  parameter int          ADDR_W      = 7,
  parameter int          FIFO_DEPTH  = 8,
  parameter int          SYNC_STAGES = 2,
  parameter logic [15:0] REG_TAG     = 16'hA5C3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              host_cs_n,
  input  logic              host_rd_n,
  input  logic [ADDR_W-1:0] host_addr,
  input  logic              host_fifo_sel,
  input  logic              host_bus16,
  output logic [DATA_W-1:0] host_dout,
  output logic [1:0]        host_doe,
  input  logic              rxq_push,
  input  logic [DATA_W-1:0] rxq_push_data,
  output logic              rxq_full,
  output logic              rxq_underflow
);

  logic [1:0]        rst_pipe_q;
  logic              rst_int_n;
  logic              act_s, cyc_start, cyc_stop;
  logic              fifo_pop, fifo_empty;
  logic [DATA_W-1:0] fifo_head;

  // Asynchronous assertion, synchronous release.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_int_n = rst_pipe_q[1];

  rxq_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst_n (rst_int_n),
    .cs_n  (host_cs_n),
    .rd_n  (host_rd_n),
    .act   (act_s),
    .start (cyc_start),
    .stop  (cyc_stop)
  );

  rxq_fifo #(.DATA_W(DATA_W), .DEPTH(FIFO_DEPTH)) u_fifo (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .push      (rxq_push),
    .push_data (rxq_push_data),
    .pop       (fifo_pop),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .full      (rxq_full)
  );

  rxq_read_ctrl #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .REG_TAG(REG_TAG)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_int_n),
    .act       (act_s),
    .start     (cyc_start),
    .stop      (cyc_stop),
    .fifo_sel  (host_fifo_sel),
    .addr      (host_addr),
    .bus16     (host_bus16),
    .head      (fifo_head),
    .empty     (fifo_empty),
    .pop       (fifo_pop),
    .dout      (host_dout),
    .doe       (host_doe),
    .underflow (rxq_underflow)
  );

endmodule

// File: rtl/rxq_burst_port_chk.sv
module rxq_burst_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       act,
  input logic [1:0] doe,
  input logic       pop,
  input logic       empty,
  input logic       full,
  input logic       uflow
);

  assert_release_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !act |-> (doe == 2'b00));

  assert_single_pop_R3: assert property (@(posedge clk) disable iff (!rst_n)
    pop |=> !pop);

  assert_upper_needs_lower_R5: assert property (@(posedge clk) disable iff (!rst_n)
    doe[1] |-> doe[0]);

  assert_no_empty_pop_R6: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);

  assert_sticky_underflow_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !$fell(uflow));

  assert_full_holds_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (full && !pop) |=> full);

endmodule

bind rxq_burst_port rxq_burst_port_chk u_chk (
  .clk   (clk),
  .rst_n (rst_int_n),
  .act   (act_s),
  .doe   (host_doe),
  .pop   (fifo_pop),
  .empty (fifo_empty),
  .full  (rxq_full),
  .uflow (rxq_underflow)
);

// File: tb/rxq_burst_port_tb.sv
module rxq_burst_port_tb;

  localparam int          DEPTH = 4;
  localparam logic [15:0] TAG   = 16'hA5C3;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        host_cs_n, host_rd_n, host_fifo_sel, host_bus16;
  logic [6:0]  host_addr;
  logic [31:0] host_dout;
  logic [1:0]  host_doe;
  logic        rxq_push;
  logic [31:0] rxq_push_data;
  logic        rxq_full, rxq_underflow;

  int          n_chk = 0;
  int          n_fail = 0;
  logic [31:0] q[$];
  bit          uflow_m = 1'b0;

  always #5 clk = ~clk;

  rxq_burst_port #(
    .DATA_W(32), .ADDR_W(7), .FIFO_DEPTH(DEPTH), .SYNC_STAGES(2), .REG_TAG(TAG)
  ) u_dut (
    .clk(clk), .rst_n(rst_n), .host_cs_n(host_cs_n), .host_rd_n(host_rd_n),
    .host_addr(host_addr), .host_fifo_sel(host_fifo_sel), .host_bus16(host_bus16),
    .host_dout(host_dout), .host_doe(host_doe), .rxq_push(rxq_push),
    .rxq_push_data(rxq_push_data), .rxq_full(rxq_full), .rxq_underflow(rxq_underflow)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // Every clock: upper lanes never enabled in 16-bit mode (R5).
  always @(negedge clk) begin
    if (rst_n && host_doe[0] && host_bus16)
      chk("R5 upper lanes off", {31'b0, host_doe[1]}, 32'd0);
  end

  task automatic push_word(input logic [31:0] w);
    @(negedge clk);
    rxq_push      = 1'b1;
    rxq_push_data = w;
    @(negedge clk);
    rxq_push = 1'b0;
    if (q.size() < DEPTH) q.push_back(w);
  endtask

  // order: 0 both together, 1 cs first, 2 rd first
  task automatic host_read(input bit sel, input logic [6:0] a, input bit b16,
                           input int order, input int hold, input string req);
    logic [31:0] exp, w;
    bit          popit;
    popit = 1'b0;
    if (sel) begin
      if (q.size() == 0) begin
        exp     = '0;
        uflow_m = 1'b1;
      end else begin
        w     = q[0];
        exp   = b16 ? (a[0] ? {16'b0, w[31:16]} : {16'b0, w[15:0]}) : w;
        popit = !b16 || a[0];
      end
    end else begin
      exp = {TAG, 9'b0, a};
      if (b16) exp[31:16] = '0;
    end
    @(negedge clk);
    host_addr = a; host_fifo_sel = sel; host_bus16 = b16;
    @(negedge clk);
    if (order == 1) begin host_cs_n = 1'b0; @(negedge clk); host_rd_n = 1'b0; end
    else if (order == 2) begin host_rd_n = 1'b0; @(negedge clk); host_cs_n = 1'b0; end
    else begin host_cs_n = 1'b0; host_rd_n = 1'b0; end
    repeat (hold) @(negedge clk);
    chk({req, " enables"}, {30'b0, host_doe}, {30'b0, ~b16, 1'b1});
    chk({req, " data"}, host_dout, exp);
    if (order == 1) begin host_rd_n = 1'b1; @(negedge clk); host_cs_n = 1'b1; end
    else if (order == 2) begin host_cs_n = 1'b1; @(negedge clk); host_rd_n = 1'b1; end
    else begin host_cs_n = 1'b1; host_rd_n = 1'b1; end
    repeat (4) @(negedge clk);
    chk({req, " R1 released"}, {30'b0, host_doe}, 32'd0);
    if (popit) void'(q.pop_front());
    chk({req, " R6 underflow flag"}, {31'b0, rxq_underflow}, {31'b0, uflow_m});
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    host_cs_n = 1'b1; host_rd_n = 1'b1; host_addr = '0;
    host_fifo_sel = 1'b0; host_bus16 = 1'b0;
    rxq_push = 1'b0; rxq_push_data = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 reset enables", {30'b0, host_doe}, 32'd0);
    chk("R6 reset underflow", {31'b0, rxq_underflow}, 32'd0);
    chk("R8 reset full", {31'b0, rxq_full}, 32'd0);

    // Register path
    host_read(1'b0, 7'h25, 1'b0, 0, 5, "R7 reg 32-bit");
    host_read(1'b0, 7'h5A, 1'b1, 0, 5, "R7 reg 16-bit");

    // Empty FIFO
    host_read(1'b1, 7'h12, 1'b0, 0, 5, "R6 empty read");

    // 32-bit burst with changing upper address and strobe orders
    push_word(32'h1111_2222);
    push_word(32'h3333_4444);
    push_word(32'h5555_6666);
    host_read(1'b0, 7'h08, 1'b0, 0, 5, "R7 reg read no pop");
    host_read(1'b1, 7'h03, 1'b0, 0, 5, "R2 R4 burst 0");
    host_read(1'b1, 7'h7C, 1'b0, 1, 5, "R9 cs first");
    host_read(1'b1, 7'h41, 1'b0, 2, 5, "R9 rd first");

    // Long hold pops once
    push_word(32'hDEAD_BEEF);
    push_word(32'hCAFE_F00D);
    host_read(1'b1, 7'h10, 1'b0, 0, 40, "R3 long hold");

    // Chip select alone opens no cycle
    @(negedge clk);
    host_fifo_sel = 1'b1;
    host_cs_n = 1'b0;
    repeat (10) @(negedge clk);
    chk("R1 cs only", {30'b0, host_doe}, 32'd0);
    host_cs_n = 1'b1;
    repeat (4) @(negedge clk);
    host_read(1'b1, 7'h11, 1'b0, 0, 5, "R3 R1 next entry");

    // 16-bit halves
    push_word(32'h89AB_CDEF);
    push_word(32'h0123_4567);
    host_read(1'b1, 7'h20, 1'b1, 0, 5, "R5 low half");
    host_read(1'b1, 7'h20, 1'b1, 0, 5, "R5 low half again");
    host_read(1'b1, 7'h21, 1'b1, 1, 5, "R5 high half");
    host_read(1'b1, 7'h22, 1'b1, 0, 5, "R5 next low half");

    // Full and dropped pushes
    push_word(32'hA000_0001);
    push_word(32'hA000_0002);
    push_word(32'hA000_0003);
    push_word(32'hA000_0004);
    push_word(32'hA000_0005);
    @(negedge clk);
    chk("R8 full flag", {31'b0, rxq_full}, 32'd1);
    host_read(1'b1, 7'h30, 1'b0, 0, 5, "R8 drain 0");
    host_read(1'b1, 7'h31, 1'b0, 2, 5, "R8 drain 1");
    host_read(1'b1, 7'h32, 1'b0, 1, 5, "R8 drain 2");
    host_read(1'b1, 7'h33, 1'b0, 0, 5, "R8 drain 3");
    host_read(1'b1, 7'h34, 1'b0, 0, 5, "R8 R6 dropped push absent");
    chk("R8 not full after drain", {31'b0, rxq_full}, 32'd0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule